// File: doc/BRIEF.md
# Ring-Addressed Fixed Delay Line

This block delays a WIDTH-bit sample stream by exactly TAPS clock cycles. Seen from its ports it cannot be told apart from a chain of TAPS flip-flop stages. Inside, it is built differently so that very little storage switches each cycle:

- an input stage register;
- a bank of TAPS-2 storage columns, selected by a rotating one-hot pointer;
- an output stage register.

Each cycle, only the column under the pointer is touched. That column is read into the output stage, refilled from the input stage, and the pointer then moves on by one column. Every other column holds its value.

The block is meant for datapaths that need long fixed delays with low switching activity, such as aligning samples around a transform or correlator. An optional enable stalls the whole line. When the enable is low, the pointer and both stage registers hold, so the delay counts enabled cycles only. With HAS_EN set to 0 the enable port is ignored and the line advances every cycle.

TAPS must be at least 4; smaller values stop elaboration. The storage columns are not reset, so the output is defined by the input stream only after TAPS enabled cycles.

Top module: `lat_ring_delay`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, dout is all zeros and the column pointer selects column 0 with exactly one bit set.
- R2: Once TAPS enabled cycles have passed since reset, dout in each cycle equals the din value sampled TAPS enabled clock edges earlier.
- R3: In a cycle where en is low (HAS_EN=1), dout, the pointer and both stage registers keep their values, and no sample is lost or repeated once en returns high.
- R4: The column pointer has exactly one bit set in every cycle out of reset.
- R5: On every enabled edge the pointer moves from column i to column i+1, and from the last column (TAPS-3) back to column 0.
- R6: With HAS_EN=0 the en input has no effect: dout equals din delayed by exactly TAPS clock edges, whatever en does.
- R7: Asserting reset in the middle of a stream clears dout to zero and restarts the fill count; after TAPS further enabled cycles the R2 relation holds again.
- R8: On any edge at most one storage column is written, and none is written when the line is stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, applied on the clock edge |
| en | input | 1 | Advance enable; ignored when HAS_EN=0 |
| din | input | WIDTH | Sample entering the line |
| dout | output | WIDTH | Sample leaving the line, TAPS enabled cycles later |

## Verification
The risky coincidence is a single column being drained into the output stage and refilled from the input stage on the same edge. In that same cycle the enable may also drop just as the pointer wraps from the last column to column 0. Random enable patterns at a 70 percent duty, together with directed long stalls and alternating enables placed over the wrap, make both events land on one edge many times. Each output is judged against a bench history of enabled inputs, and each stalled cycle is judged against the previous output value.

// File: rtl/lrd_pkg.sv
package lrd_pkg;
   localparam int unsigned LRD_MIN_TAPS = 4;

   // number of storage columns between the two stage registers
   function automatic int unsigned lrd_cols(input int unsigned taps);
      return taps - 2;
   endfunction
endpackage

// File: rtl/lrd_stage_reg.sv
module lrd_stage_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (ce) q <= d;
   end
endmodule

// File: rtl/lrd_ring_ptr.sv
module lrd_ring_ptr #(
   parameter int unsigned COLS = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   output logic [COLS-1:0] sel
);
   localparam logic [COLS-1:0] HOME = COLS'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)    sel <= HOME;
      else if (step) sel <= {sel[COLS-2:0], sel[COLS-1]};
   end
endmodule

// File: rtl/lrd_col_array.sv
module lrd_col_array #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned COLS  = 6
) (
   input  logic             clk,
   input  logic [COLS-1:0]  sel,
   input  logic [COLS-1:0]  wr_sel,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata
);
   logic [COLS-1:0][WIDTH-1:0] col_data;

   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [WIDTH-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (wr_sel[c]) cell_q <= wdata;
      end
      assign col_data[c] = cell_q;
   end

   // AND-OR read through the one-hot select
   always_comb begin
      rdata = '0;
      for (int c = 0; c < COLS; c++) begin
         rdata = rdata | ({WIDTH{sel[c]}} & col_data[c]);
      end
   end
endmodule

// File: rtl/lat_ring_delay.sv
module lat_ring_delay
   import lrd_pkg::*;
#(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned TAPS   = 8,
   parameter bit          HAS_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   localparam int unsigned COLS = lrd_cols(TAPS);

   if (TAPS < LRD_MIN_TAPS) begin : g_taps_bad
      $error("lat_ring_delay: TAPS must be at least 4");
   end
   if (WIDTH < 1) begin : g_width_bad
      $error("lat_ring_delay: WIDTH must be at least 1");
   end

   logic en_eff;
   if (HAS_EN) begin : g_en
      assign en_eff = en;
   end else begin : g_free
      logic unused_en;
      assign unused_en = en;
      assign en_eff    = 1'b1;
   end

   logic [WIDTH-1:0] in_q;
   logic [WIDTH-1:0] rd_data;
   logic [COLS-1:0]  col_sel;
   logic [COLS-1:0]  wr_sel;

   assign wr_sel = col_sel & {COLS{en_eff}};

   lrd_stage_reg #(.WIDTH(WIDTH)) u_in_stage (
      .clk(clk), .rst_n(rst_n), .ce(en_eff), .d(din), .q(in_q)
   );

   lrd_ring_ptr #(.COLS(COLS)) u_ptr (
      .clk(clk), .rst_n(rst_n), .step(en_eff), .sel(col_sel)
   );

   lrd_col_array #(.WIDTH(WIDTH), .COLS(COLS)) u_array (
      .clk(clk), .sel(col_sel), .wr_sel(wr_sel), .wdata(in_q), .rdata(rd_data)
   );

   lrd_stage_reg #(.WIDTH(WIDTH)) u_out_stage (
      .clk(clk), .rst_n(rst_n), .ce(en_eff), .d(rd_data), .q(dout)
   );
endmodule

// File: rtl/lat_ring_delay_chk.sv
module lat_ring_delay_chk #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned TAPS  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_eff,
   input logic [WIDTH-1:0] din,
   input logic [WIDTH-1:0] dout,
   input logic [TAPS-3:0]  col_sel,
   input logic [TAPS-3:0]  wr_sel
);
   localparam int unsigned COLS = TAPS - 2;
   localparam int unsigned CW   = $clog2(TAPS + 1);

   // plain shift-register reference, advanced on enabled edges
   logic [WIDTH-1:0] ref_q [TAPS];
   logic [CW-1:0]    seen_q;

   always_ff @(posedge clk) begin
      if (en_eff) begin
         ref_q[0] <= din;
         for (int i = 1; i < TAPS; i++) ref_q[i] <= ref_q[i-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                          seen_q <= '0;
      else if (en_eff && seen_q < CW'(TAPS)) seen_q <= seen_q + 1'b1;
   end

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dout == '0) && (col_sel == COLS'(1)));

   // R2
   shift_equiv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q == CW'(TAPS)) |-> (dout == ref_q[TAPS-1]));

   // R3
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_eff |=> $stable(col_sel) && $stable(dout));

   // R4
   ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(col_sel) == 1);

   // R5
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_eff |=> (col_sel == {$past(col_sel[COLS-2:0]), $past(col_sel[COLS-1])}));

   // R8
   single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel) && (!en_eff -> (wr_sel == '0)));
endmodule

bind lat_ring_delay lat_ring_delay_chk #(.WIDTH(WIDTH), .TAPS(TAPS)) u_chk (
   .clk(clk), .rst_n(rst_n), .en_eff(en_eff), .din(din), .dout(dout),
   .col_sel(col_sel), .wr_sel(wr_sel)
);

// File: tb/lat_ring_delay_tb.sv
`timescale 1ns/1ps
module lat_ring_delay_tb;
   localparam int W = 8;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] dout, dout_free;

   always #2.5 clk = ~clk;

   lat_ring_delay #(.WIDTH(W), .TAPS(N), .HAS_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .din(din), .dout(dout)
   );
   lat_ring_delay #(.WIDTH(W), .TAPS(N), .HAS_EN(1'b0)) u_dut_free (
      .clk(clk), .rst_n(rst_n), .en(en), .din(din), .dout(dout_free)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [W-1:0] hist   [N];
   logic [W-1:0] hist_f [N];
   int fill   = 0;
   int fill_f = 0;

   task automatic chk(input bit ok, input string req,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // one clock: drive at negedge, update model and sample 1 ns after the edge
   task automatic step(input logic [W-1:0] d, input logic e, input string req);
      logic [W-1:0] prev;
      @(negedge clk);
      din  = d;
      en   = e;
      prev = dout;
      @(posedge clk);
      #1;
      if (e) begin
         for (int i = N-1; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = d;
         if (fill < N) fill++;
      end
      for (int i = N-1; i > 0; i--) hist_f[i] = hist_f[i-1];
      hist_f[0] = d;
      if (fill_f < N) fill_f++;
      if (!e)            chk(dout === prev, "R3 stall hold", dout, prev);
      else if (fill >= N) chk(dout === hist[N-1], req, dout, hist[N-1]);
      if (fill_f >= N)   chk(dout_free === hist_f[N-1], "R6 enable ignored", dout_free, hist_f[N-1]);
   endtask

   task automatic do_reset(input string req);
      @(negedge clk);
      rst_n = 1'b0;
      en    = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk(dout === '0, req, dout, '0);
      chk(dout_free === '0, req, dout_free, '0);
      fill   = 0;
      fill_f = 0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd24681357);
      do_reset("R1 reset state");
      // R1: first cycle after release, stalled so nothing moves
      step(8'h11, 1'b0, "R1");
      chk(dout === '0, "R1 after release", dout, '0);

      // R2 directed ramp, several wraps of the column ring
      for (int k = 0; k < 4*N; k++) step(W'(k + 1), 1'b1, "R2 ramp");
      // R2 all-ones / all-zeros alternation
      for (int k = 0; k < 2*N; k++) step((k % 2) ? '1 : '0, 1'b1, "R2 toggle");
      // R3 alternating enable, read and refill of one column meet stalls
      for (int k = 0; k < 3*N; k++) step(W'(8'hA0 + k), (k % 2) == 0, "R3 alternating");
      // R3 long stall placed around the pointer wrap
      for (int k = 0; k < N-3; k++) step(W'(8'h50 + k), 1'b1, "R5 to wrap");
      for (int k = 0; k < 20; k++)  step(W'($urandom), 1'b0, "R3 long stall");
      for (int k = 0; k < 2*N; k++) step(W'(8'hC0 + k), 1'b1, "R5 wrap resume");

      // R2/R3 constrained random, enable about 70 percent
      for (int k = 0; k < 3000; k++) begin
         logic e;
         e = ($urandom % 10) < 7;
         step(W'($urandom), e, "R2 random");
      end

      // R7 reset mid-stream, then refill
      do_reset("R7 mid-stream reset");
      for (int k = 0; k < 3*N; k++) step(W'(8'h30 + 3*k), 1'b1, "R7 refill");
      for (int k = 0; k < 500; k++) step(W'($urandom), ($urandom % 4) != 0, "R7 random");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule